// File: doc/BRIEF.md
# Line Loss-of-Signal Detector

This block watches a recovered receive bit stream, one bit per accepted receive-clock cycle, and drives an active-low loss-of-signal flag. The flag is declared when a long unbroken run of zeros arrives. It is withdrawn only after a full observation window of clean traffic. Clean traffic here means no run of zeros long enough to count as an excessive-zero event under the selected line rules.

A two-bit line-mode input picks the rule for an excessive-zero event. In the DS3 and STS-1 rates a run of three zeros is already excessive. In E3 the run must reach four zeros. Bits are scored only on cycles where the valid strobe is high. The declare threshold and the window length are parameters, so the block can be placed anywhere within the allowed tolerance band.

Top module: `los_detector`

## Requirements
- R1: After synchronous reset the flag is declared (`los_n` = 0), both counters are cleared, and `los_n` stays 0 until WIN_LEN (default 175) consecutive clean valid bits have been accepted.
- R2: `los_n` is active low: 0 while loss is declared and 1 otherwise. It only falls on the edge where the declare threshold is reached.
- R3: While loss is not declared, the flag is set on the edge that accepts the LOS_THRESH-th (default 175) consecutive valid zero. A run of LOS_THRESH-1 zeros followed by a one leaves it clear.
- R4: A valid 1 resets the zero-run count to 0. The count saturates at LOS_THRESH and never wraps, so an arbitrarily long zero run keeps the flag declared.
- R5: With mode DS3 or STS-1, every valid zero that brings the run to 3 or more is an excessive-zero event. Runs of at most 2 zeros are clean.
- R6: With mode E3, every valid zero that brings the run to 4 or more is an excessive-zero event. Runs of up to 3 zeros are clean.
- R7: Mode encoding on `line_mode`: 2'b00 DS3, 2'b01 E3, 2'b10 STS-1, 2'b11 treated as DS3.
- R8: While declared, a window counter advances once per clean valid bit and any excessive-zero event restarts it at 0. The flag clears on the edge that accepts the WIN_LEN-th consecutive clean bit.
- R9: Cycles with `rx_valid` low change no state: the run count, the window count, the flag and the latched mode all hold.
- R10: On a valid cycle whose `line_mode` differs from the mode of the previous valid cycle, the run restarts. It becomes 1 for a zero and 0 for a one, so a partial run is never scored under the new rule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_bit | input | 1 | Recovered receive data bit |
| rx_valid | input | 1 | Qualifies `rx_bit`; low cycles are ignored |
| line_mode | input | 2 | Line rule select (00 DS3, 01 E3, 10 STS-1, 11 DS3) |
| los_n | output | 1 | Loss-of-signal flag, active low |

## Verification
The bench checks the exact release edge at both window boundaries. A design that counts one bit too few or too many moves the rising edge of `los_n` by one cycle. A zero pattern of the form 1000 separates the mode rules: it releases the flag in E3 but must hold it forever in STS-1 or in mode 11. A design that compares against the wrong limit therefore either never releases or releases too early. A three-zero run in E3 is followed by two zeros after a switch to DS3. A design that keeps the old run would log an event there and release late. Long bursts with the strobe low are placed inside runs and windows; a design that counts them shifts every later edge.

// File: rtl/los_pkg.sv
`timescale 1ns/1ps
package los_pkg;

  typedef enum logic [1:0] {
    LM_DS3  = 2'b00,
    LM_E3   = 2'b01,
    LM_STS1 = 2'b10,
    LM_ALT  = 2'b11
  } line_mode_e;

  // Zero-run length that counts as an excessive-zero event for a mode.
  function automatic int unsigned excess_len(input logic [1:0] mode,
                                             input int unsigned short_run,
                                             input int unsigned long_run);
    return (mode == LM_E3) ? long_run : short_run;
  endfunction

  // Next zero-run count: a one clears, a mode switch restarts, else saturating step.
  function automatic int unsigned next_run(input int unsigned cur,
                                           input logic bit_in,
                                           input logic restart,
                                           input int unsigned cap);
    if (bit_in)      return 0;
    if (restart)     return 1;
    if (cur >= cap)  return cap;
    return cur + 1;
  endfunction

  // Next window count, wrapping to zero after the last position.
  function automatic int unsigned next_window(input int unsigned cur,
                                              input int unsigned last);
    return (cur >= last) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/los_mode_track.sv
`timescale 1ns/1ps
module los_mode_track
  import los_pkg::*;
#(
  parameter int unsigned RUN_W  = 8,
  parameter int unsigned DS3_EZ = 3,
  parameter int unsigned E3_EZ  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic [1:0]       line_mode,
  output logic             mode_chg,
  output logic [RUN_W-1:0] ez_limit
);

  logic [1:0] mode_q;

  // Mode of the last accepted bit; only valid cycles move it (R9).
  always_ff @(posedge clk) begin
    if (rst)           mode_q <= LM_DS3;
    else if (rx_valid) mode_q <= line_mode;
  end

  assign mode_chg = (line_mode != mode_q);
  assign ez_limit = RUN_W'(excess_len(line_mode, DS3_EZ, E3_EZ));

  a_r10_mode_latched: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> (mode_q == $past(line_mode)));

  a_r9_mode_hold: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> $stable(mode_q));

  // R7: only E3 selects the longer limit
  a_r7_limit_sel: assert property (@(posedge clk) disable iff (rst)
    (line_mode != LM_E3) |-> (ez_limit == RUN_W'(DS3_EZ)));

endmodule

// File: rtl/los_run_counter.sv
`timescale 1ns/1ps
module los_run_counter
  import los_pkg::*;
#(
  parameter int unsigned LOS_THRESH = 175,
  parameter int unsigned RUN_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic             rx_bit,
  input  logic             mode_chg,
  input  logic [RUN_W-1:0] ez_limit,
  output logic             ez_event,
  output logic             thresh_hit
);

  localparam logic [RUN_W-1:0] THR_V = RUN_W'(LOS_THRESH);

  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_next;

  assign run_next = RUN_W'(next_run(32'(run_q), rx_bit, mode_chg, LOS_THRESH));

  always_ff @(posedge clk) begin
    if (rst)           run_q <= '0;
    else if (rx_valid) run_q <= run_next;
  end

  assign ez_event   = rx_valid && !rx_bit && (run_next >= ez_limit);
  assign thresh_hit = rx_valid && (run_next == THR_V);

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    run_q <= THR_V);

  a_r4_one_clears: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_bit) |=> (run_q == '0));

  a_r10_restart: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_bit && mode_chg) |=> (run_q == RUN_W'(1)));

  a_r9_run_hold: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> $stable(run_q));

endmodule

// File: rtl/los_window.sv
`timescale 1ns/1ps
module los_window
  import los_pkg::*;
#(
  parameter int unsigned WIN_LEN = 175,
  parameter int unsigned WIN_W   = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_valid,
  input  logic ez_event,
  input  logic thresh_hit,
  output logic loss_q,
  output logic win_done
);

  localparam logic [WIN_W-1:0] LAST_V = WIN_W'(WIN_LEN - 1);

  logic [WIN_W-1:0] win_q;

  assign win_done = loss_q && rx_valid && !ez_event && (win_q == LAST_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      loss_q <= 1'b1;
      win_q  <= '0;
    end else if (rx_valid) begin
      if (!loss_q) begin
        if (thresh_hit) begin
          loss_q <= 1'b1;
          win_q  <= '0;
        end
      end else if (ez_event) begin
        win_q <= '0;
      end else if (win_done) begin
        loss_q <= 1'b0;
        win_q  <= '0;
      end else begin
        win_q <= WIN_W'(next_window(32'(win_q), WIN_LEN - 1));
      end
    end
  end

  a_r8_event_restart: assert property (@(posedge clk) disable iff (rst)
    (loss_q && rx_valid && ez_event) |=> (loss_q && win_q == '0));

  a_r3_declare: assert property (@(posedge clk) disable iff (rst)
    (!loss_q && thresh_hit) |=> loss_q);

  a_r8_idle_window: assert property (@(posedge clk) disable iff (rst)
    !loss_q |-> (win_q == '0));

  a_r9_window_hold: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> ($stable(win_q) && $stable(loss_q)));

endmodule

// File: rtl/los_detector.sv
`timescale 1ns/1ps
module los_detector
  import los_pkg::*;
#(
  parameter int unsigned LOS_THRESH = 175,
  parameter int unsigned WIN_LEN    = 175,
  parameter int unsigned DS3_EZ     = 3,
  parameter int unsigned E3_EZ      = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_bit,
  input  logic       rx_valid,
  input  logic [1:0] line_mode,
  output logic       los_n
);

  localparam int unsigned RUN_W = $clog2(LOS_THRESH + 1);
  localparam int unsigned WIN_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;

  logic             mode_chg;
  logic [RUN_W-1:0] ez_limit;
  logic             ez_event;
  logic             thresh_hit;
  logic             loss_q;
  logic             win_done;

  los_mode_track #(
    .RUN_W (RUN_W),
    .DS3_EZ(DS3_EZ),
    .E3_EZ (E3_EZ)
  ) u_mode (
    .clk      (clk),
    .rst      (rst),
    .rx_valid (rx_valid),
    .line_mode(line_mode),
    .mode_chg (mode_chg),
    .ez_limit (ez_limit)
  );

  los_run_counter #(
    .LOS_THRESH(LOS_THRESH),
    .RUN_W     (RUN_W)
  ) u_run (
    .clk       (clk),
    .rst       (rst),
    .rx_valid  (rx_valid),
    .rx_bit    (rx_bit),
    .mode_chg  (mode_chg),
    .ez_limit  (ez_limit),
    .ez_event  (ez_event),
    .thresh_hit(thresh_hit)
  );

  los_window #(
    .WIN_LEN(WIN_LEN),
    .WIN_W  (WIN_W)
  ) u_win (
    .clk       (clk),
    .rst       (rst),
    .rx_valid  (rx_valid),
    .ez_event  (ez_event),
    .thresh_hit(thresh_hit),
    .loss_q    (loss_q),
    .win_done  (win_done)
  );

  assign los_n = ~loss_q;

  a_r2_fall_on_threshold: assert property (@(posedge clk) disable iff (rst)
    $fell(los_n) |-> $past(thresh_hit));

  a_r8_rise_on_window: assert property (@(posedge clk) disable iff (rst)
    $rose(los_n) |-> $past(win_done));

  a_r5_event_needs_zero: assert property (@(posedge clk) disable iff (rst)
    ez_event |-> (rx_valid && !rx_bit));

endmodule

// File: tb/test_los_detector.sv
`timescale 1ns/1ps
module test_los_detector;

  localparam int CLK_PERIOD = 10;
  localparam int THR = 175;
  localparam int WIN = 175;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_bit = 1'b0;
  logic       rx_valid = 1'b0;
  logic [1:0] line_mode = 2'b00;
  logic       los_n;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic  exp_q[$];
  string tag_q[$];

  // independent reference state
  int       m_run = 0;
  int       m_clean = 0;
  bit       m_loss = 1;
  bit [1:0] m_mode = 2'b00;

  always #(CLK_PERIOD/2) clk = ~clk;

  los_detector i_los_detector (
    .clk      (clk),
    .rst      (rst),
    .rx_bit   (rx_bit),
    .rx_valid (rx_valid),
    .line_mode(line_mode),
    .los_n    (los_n)
  );

  task automatic check(input bit ok, input string tag, input logic act, input logic exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s los_n=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: apply one cycle, step the reference, push the expectation.
  task automatic send(input logic b, input logic [1:0] m, input logic v, input string tag);
    int lim;
    bit ev;
    @(negedge clk);
    rx_bit = b; line_mode = m; rx_valid = v;
    if (v) begin
      lim = (m == 2'b01) ? 4 : 3;
      if (b)                m_run = 0;
      else if (m != m_mode) m_run = 1;
      else if (m_run < THR) m_run = m_run + 1;
      m_mode = m;
      ev = !b && (m_run >= lim);
      if (!m_loss) begin
        if (m_run == THR) begin m_loss = 1; m_clean = 0; end
      end else if (ev) begin
        m_clean = 0;
      end else begin
        m_clean++;
        if (m_clean == WIN) begin m_loss = 0; m_clean = 0; end
      end
    end
    exp_q.push_back(!m_loss);
    tag_q.push_back(tag);
  endtask

  task automatic burst(input logic b, input logic [1:0] m, input int n, input string tag);
    for (int i = 0; i < n; i++) send(b, m, 1'b1, tag);
  endtask

  // groups of a single one followed by z zeros
  task automatic groups(input logic [1:0] m, input int z, input int n, input string tag);
    for (int g = 0; g < n; g++) begin
      send(1'b1, m, 1'b1, tag);
      for (int k = 0; k < z; k++) send(1'b0, m, 1'b1, tag);
    end
  endtask

  task automatic idle(input logic [1:0] m, input int n, input string tag);
    for (int i = 0; i < n; i++) send(1'b0, m, 1'b0, tag);
  endtask

  // Monitor: compare each popped expectation after the edge it belongs to.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(los_n === e, t, los_n, e);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog los_n=%0b expected=done", los_n);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(los_n === 1'b0, "R1 reset state", los_n, 1'b0);
    rst = 1'b0;

    // R1/R8: 174 clean ones keep loss declared, 175th releases
    burst(1'b1, 2'b00, WIN - 1, "R1 window not complete");
    send(1'b1, 2'b00, 1'b1, "R8 release on last window bit");

    // R3: 174 zeros then a one stays clear; then a full run declares
    burst(1'b0, 2'b00, THR - 1, "R3 short run no declare");
    send(1'b1, 2'b00, 1'b1, "R4 one clears run");
    burst(1'b0, 2'b00, THR, "R3 declare on threshold");
    // R4: saturation, long run holds loss
    burst(1'b0, 2'b00, 300, "R4 saturated run");

    // R5/R8: event restarts window, then clean 100 pattern releases
    burst(1'b1, 2'b00, 100, "R8 partial window");
    burst(1'b0, 2'b00, 3, "R5 three zeros is event");
    groups(2'b00, 2, 60, "R5 runs of two are clean");

    // R9: strobe-low zeros inside a run are ignored
    burst(1'b0, 2'b00, 100, "R9 run part one");
    idle(2'b00, 60, "R9 idle hold");
    burst(1'b0, 2'b00, THR - 100, "R9 declare after idle");

    // R6: E3 accepts runs of three zeros
    groups(2'b01, 3, 44, "R6 e3 runs of three clean");
    burst(1'b0, 2'b01, THR, "R6 e3 declare");
    groups(2'b01, 4, 40, "R6 e3 four zeros keep loss");

    // R7: STS-1 and mode 11 use the short rule
    groups(2'b10, 3, 60, "R7 sts1 holds loss on 1000");
    burst(1'b1, 2'b10, WIN, "R7 sts1 release");
    burst(1'b0, 2'b11, THR, "R7 mode11 declare");
    groups(2'b11, 3, 50, "R7 mode11 holds loss on 1000");

    // R9: idle inside the window does not advance it
    burst(1'b1, 2'b11, 100, "R9 window part");
    idle(2'b11, 80, "R9 window idle");
    burst(1'b1, 2'b11, WIN - 100, "R9 window finish");

    // R10: mode switch restarts a partial run
    burst(1'b0, 2'b01, THR, "R10 declare in e3");
    burst(1'b1, 2'b01, 100, "R10 clean ones");
    burst(1'b0, 2'b01, 3, "R10 e3 three zeros clean");
    burst(1'b0, 2'b00, 2, "R10 restart after switch");
    burst(1'b1, 2'b00, 70, "R10 release on exact count");
    burst(1'b1, 2'b00, 5, "R2 clear stays high");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule